// File: doc/BRIEF.md
# Storage Card Attribute Configuration Space

This block is the attribute-memory face of a removable storage card. A host reads and writes single bytes through one access port. Below a fixed configuration base address, reads return bytes of the card information structure. The structure bytes come from an external byte ROM, which the block addresses directly. At and above the base sit four byte-wide configuration registers: an option register, a configuration-and-status register, a pin-replacement register and a socket/copy register.

The block also produces the card's host interrupt. That output is gated by three independent sources: the status interrupt bit, two bits of an externally held device-control value, and the hold bit of the option register. Writing the option register with its hold bit set sends a one-cycle reset pulse to the rest of the card. The device's own interrupt request is a level, and the status register copies it every clock.

Reads are combinational from the address. Writes take effect on the clock edge at which `acc_wr` is high.

Top module: `attr_cfg_space`

## Requirements
- R1: A read at an address below 0x200 returns the ROM byte at that address when the address is below 0x14A. Any other address below 0x200 reads as 0x00.
- R2: Above the base, the registers sit at offsets 0x00 (option), 0x02 (status), 0x04 (pin) and 0x06 (socket/copy). The socket/copy register and every other offset read 0x00. A write to any of them changes nothing.
- R3: A write to the option register stores the written byte ANDed with 0xCF. The stored value is read back at offset 0x00.
- R4: A write to the option register with bit 7 set drives `card_rst_pulse` high for exactly the one cycle that follows the write edge.
- R5: A write to the status register loads bits 6, 5, 4 and 2 from the written byte and keeps bit 7. Bits 0 and 3 always read 0.
- R6: When a status write flips bit 2 (power-down), the ready flag (pin-register bit 5) becomes 1. It stays 1 until reset.
- R7: While `ctl_irq_off` is high, a status read shows bit 1 as 0. When `ctl_irq_off` is low, the read shows the stored bit 1.
- R8: A pin-register read returns 0x0C ORed with the ready flag in bit 5. A write to the pin register leaves what it reads unchanged.
- R9: `host_irq` is high exactly when all four of these are 0: status bit 1, `ctl_irq_off`, `ctl_soft_rst` and option bit 7.
- R10: Status bit 1 takes the value of `dev_irq_req` at each clock edge. This holds even when a status write lands on the same edge.
- R11: A clock edge with `rst_n` low clears the option, status and ready state and the reset pulse. Writes below the base leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | 12 | Byte address of the attribute access |
| acc_wr | input | 1 | Write strobe, sampled at the clock edge |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for `acc_addr`, combinational |
| rom_addr | output | 9 | Byte address presented to the information ROM |
| rom_data | input | 8 | Byte returned by the information ROM |
| dev_irq_req | input | 1 | Interrupt request level from the device |
| ctl_irq_off | input | 1 | Device-control interrupt-disable bit |
| ctl_soft_rst | input | 1 | Device-control software-reset bit |
| host_irq | output | 1 | Interrupt output to the host |
| card_rst_pulse | output | 1 | One-cycle reset request to the rest of the card |

## Verification
Two functions can act on status bit 1 in the same cycle: the device's interrupt level and a host write to the status register. The bench provokes the overlap by writing the status register with bit 1 both set and clear while `dev_irq_req` is held at the opposite value. It then reads the register back with the interrupt-disable bit low and with it high. The result is judged against the rule that the request level always wins over the written data. The same reference model also tracks the power-down toggle, so the ready flag is checked in these overlap cycles as well.

// File: rtl/attr_cfg_pkg.sv
// Package: attr_cfg_pkg
// Shared select codes, masks and register offsets for the attribute
// configuration space. Assumes byte-wide registers.
package attr_cfg_pkg;

    typedef enum logic [2:0] {
        SEL_INFO,   // inside the information structure
        SEL_BLANK,  // below base, past the structure
        SEL_OPT,
        SEL_STAT,
        SEL_PIN,
        SEL_SOCK,
        SEL_NONE    // unknown offset above base
    } attr_sel_e;

    localparam logic [7:0] OPT_STORE_MASK = 8'hCF;
    localparam logic [7:0] PIN_FIXED_BITS = 8'h0C;

    localparam int OFS_OPT  = 'h0;
    localparam int OFS_STAT = 'h2;
    localparam int OFS_PIN  = 'h4;
    localparam int OFS_SOCK = 'h6;

endpackage

// File: rtl/attr_addr_decode.sv
// Module: attr_addr_decode
// Classifies an attribute address as information-structure space, blank
// space or one of the configuration registers, and forms the ROM address.
// Assumes CFG_BASE >= INFO_LEN and an ADDR_W wide enough for both.
module attr_addr_decode
    import attr_cfg_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int CFG_BASE = 'h200,
    parameter int INFO_LEN = 'h14A,
    parameter int INFO_AW  = $clog2(INFO_LEN)
) (
    input  logic [ADDR_W-1:0]  addr,
    output attr_sel_e          sel,
    output logic [INFO_AW-1:0] rom_addr
);

    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] LEN_V  = ADDR_W'(INFO_LEN);

    logic [ADDR_W-1:0] rel;

    assign rel      = addr - BASE_V;
    assign rom_addr = addr[INFO_AW-1:0];

    // Purpose: pick the region or register addressed by the access.
    always_comb begin
        if (addr < BASE_V) begin
            sel = (addr < LEN_V) ? SEL_INFO : SEL_BLANK;
        end else begin
            unique case (rel)
                ADDR_W'(OFS_OPT):  sel = SEL_OPT;
                ADDR_W'(OFS_STAT): sel = SEL_STAT;
                ADDR_W'(OFS_PIN):  sel = SEL_PIN;
                ADDR_W'(OFS_SOCK): sel = SEL_SOCK;
                default:           sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/attr_cfg_regs.sv
// Module: attr_cfg_regs
// Holds the option register, the status register and the sticky ready
// flag, and issues the one-cycle card reset pulse. The status interrupt
// bit follows the device request level every cycle. Assumes a single
// access per cycle, selected by the decoder.
module attr_cfg_regs
    import attr_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  attr_sel_e  sel,
    input  logic [7:0] wdata,
    input  logic       dev_irq,
    output logic [7:0] opt_q,
    output logic [7:0] stat_q,
    output logic       ready_q,
    output logic       rst_pulse
);

    logic       wr_opt;
    logic       wr_stat;
    logic       stat_top;     // bit 7, kept across writes
    logic [2:0] stat_cfg;     // bits 6:4
    logic       stat_pdown;   // bit 2
    logic       stat_int;     // bit 1

    assign wr_opt  = wr_en && (sel == SEL_OPT);
    assign wr_stat = wr_en && (sel == SEL_STAT);
    assign stat_q  = {stat_top, stat_cfg, 1'b0, stat_pdown, stat_int, 1'b0};

    // Purpose: option register and reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opt_q     <= '0;
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= wr_opt && wdata[7];
            if (wr_opt) begin
                opt_q <= wdata & OPT_STORE_MASK;
            end
        end
    end

    // Purpose: status fields; interrupt bit tracks the device level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_top   <= 1'b0;
            stat_cfg   <= '0;
            stat_pdown <= 1'b0;
            stat_int   <= 1'b0;
        end else begin
            stat_int <= dev_irq;
            if (wr_stat) begin
                stat_cfg   <= wdata[6:4];
                stat_pdown <= wdata[2];
            end
        end
    end

    // Purpose: sticky ready flag, set when power-down is toggled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else if (wr_stat && (wdata[2] != stat_pdown)) begin
            ready_q <= 1'b1;
        end
    end

    p_opt_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_opt |=> opt_q == ($past(wdata) & 8'hCF));

    p_pulse_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> $past(wr_en && sel == SEL_OPT && wdata[7]));

    p_stat_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> (stat_q[6:4] == $past(wdata[6:4])) &&
                    (stat_q[2] == $past(wdata[2])) &&
                    (stat_q[7] == $past(stat_q[7])));

    p_ready_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && (wdata[2] != stat_q[2])) |=> ready_q);

    p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |=> ready_q);

    p_int_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> stat_q[1] == $past(dev_irq));

endmodule

// File: rtl/attr_irq_view.sv
// Module: attr_irq_view
// Forms the host interrupt from the status, device-control and option
// hold bits, and the host view of the status register with the pending
// bit hidden while interrupts are disabled. Purely combinational.
module attr_irq_view (
    input  logic [7:0] stat_q,
    input  logic       opt_hold,
    input  logic       irq_off,
    input  logic       soft_rst,
    output logic       host_irq,
    output logic [7:0] stat_view
);

    // Purpose: host interrupt gate and masked status view.
    always_comb begin
        host_irq  = !(stat_q[1] || irq_off || soft_rst || opt_hold);
        stat_view = stat_q;
        if (irq_off) begin
            stat_view[1] = 1'b0;
        end
    end

endmodule

// File: rtl/attr_cfg_space.sv
// Module: attr_cfg_space
// Top of the attribute configuration space: address decode, register
// state, interrupt gating and the read multiplexer. Reads are
// combinational; writes act on the clock edge with acc_wr high.
module attr_cfg_space
    import attr_cfg_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int CFG_BASE = 'h200,
    parameter int INFO_LEN = 'h14A,
    parameter int INFO_AW  = $clog2(INFO_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic               acc_wr,
    input  logic [7:0]         acc_wdata,
    output logic [7:0]         acc_rdata,
    output logic [INFO_AW-1:0] rom_addr,
    input  logic [7:0]         rom_data,
    input  logic               dev_irq_req,
    input  logic               ctl_irq_off,
    input  logic               ctl_soft_rst,
    output logic               host_irq,
    output logic               card_rst_pulse
);

    attr_sel_e  sel;
    logic [7:0] opt_q;
    logic [7:0] stat_q;
    logic [7:0] stat_view;
    logic       ready_q;

    attr_addr_decode #(
        .ADDR_W  (ADDR_W),
        .CFG_BASE(CFG_BASE),
        .INFO_LEN(INFO_LEN),
        .INFO_AW (INFO_AW)
    ) u_decode (
        .addr    (acc_addr),
        .sel     (sel),
        .rom_addr(rom_addr)
    );

    attr_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (acc_wr),
        .sel      (sel),
        .wdata    (acc_wdata),
        .dev_irq  (dev_irq_req),
        .opt_q    (opt_q),
        .stat_q   (stat_q),
        .ready_q  (ready_q),
        .rst_pulse(card_rst_pulse)
    );

    attr_irq_view u_irq (
        .stat_q   (stat_q),
        .opt_hold (opt_q[7]),
        .irq_off  (ctl_irq_off),
        .soft_rst (ctl_soft_rst),
        .host_irq (host_irq),
        .stat_view(stat_view)
    );

    // Purpose: return the byte selected by the current address.
    always_comb begin
        unique case (sel)
            SEL_INFO: acc_rdata = rom_data;
            SEL_OPT:  acc_rdata = opt_q;
            SEL_STAT: acc_rdata = stat_view;
            SEL_PIN:  acc_rdata = PIN_FIXED_BITS | {2'b00, ready_q, 5'b00000};
            default:  acc_rdata = 8'h00;
        endcase
    end

    p_hold_blocks_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        opt_q[7] |-> !host_irq);

    p_view_hides_int_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_irq_off && sel == SEL_STAT) |-> !acc_rdata[1]);

    p_pin_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_PIN) |-> (acc_rdata[3:2] == 2'b11) && (acc_rdata[1:0] == 2'b00));

endmodule

// File: tb/attr_cfg_space_tb.sv
`timescale 1ns/1ps
module attr_cfg_space_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] acc_addr;
    logic        acc_wr;
    logic [7:0]  acc_wdata;
    logic [7:0]  acc_rdata;
    logic [8:0]  rom_addr;
    logic [7:0]  rom_data;
    logic        dev_irq_req;
    logic        ctl_irq_off;
    logic        ctl_soft_rst;
    logic        host_irq;
    logic        card_rst_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_opt = 8'h00;
    logic [7:0] m_stat = 8'h00;
    logic       m_ready = 1'b0;
    logic       m_pulse = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    assign rom_data = 8'(rom_addr * 5 + 9);

    attr_cfg_space u_dut (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .rom_addr(rom_addr),
        .rom_data(rom_data), .dev_irq_req(dev_irq_req), .ctl_irq_off(ctl_irq_off),
        .ctl_soft_rst(ctl_soft_rst), .host_irq(host_irq), .card_rst_pulse(card_rst_pulse)
    );

    function automatic logic [7:0] model_read(logic [11:0] a, logic off);
        if (a < 12'h200) return (a < 12'h14A) ? 8'(a * 5 + 9) : 8'h00;
        case (a)
            12'h200: return m_opt;
            12'h202: return off ? (m_stat & 8'hFD) : m_stat;
            12'h204: return 8'h0C | {2'b00, m_ready, 5'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One cycle: drive, compare outputs against the model, clock, update model.
    task automatic step(logic r, logic [11:0] a, logic w, logic [7:0] d,
                        logic irq, logic off, logic sr, string tag);
        logic [7:0] ns;
        @(negedge clk);
        rst_n = r; acc_addr = a; acc_wr = w; acc_wdata = d;
        dev_irq_req = irq; ctl_irq_off = off; ctl_soft_rst = sr;
        #1;
        check8(tag, acc_rdata, model_read(a, off));
        check8("R9 host_irq", {7'b0, host_irq},
               {7'b0, !(m_stat[1] || off || sr || m_opt[7])});
        check8("R4 card_rst_pulse", {7'b0, card_rst_pulse}, {7'b0, m_pulse});
        @(posedge clk);
        if (!r) begin
            m_opt = 0; m_stat = 0; m_ready = 0; m_pulse = 0;
        end else begin
            ns = m_stat;
            m_pulse = w && (a == 12'h200) && d[7];
            if (w && a == 12'h200) m_opt = d & 8'hCF;
            if (w && a == 12'h202) begin
                if (m_stat[2] != d[2]) m_ready = 1'b1;
                ns = (m_stat & 8'h82) | (d & 8'h74);
            end
            ns[1] = irq;
            m_stat = ns;
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) step(0, 12'h200, 0, 8'h00, 0, 0, 0, "R11 reset");
        step(1, 12'h200, 0, 8'h00, 0, 0, 0, "R11 option after reset");
        step(1, 12'h202, 0, 8'h00, 0, 0, 0, "R11 status after reset");
        step(1, 12'h204, 0, 8'h00, 0, 0, 0, "R11 pin after reset");
        // R1: information space
        step(1, 12'h000, 0, 8'h00, 0, 0, 0, "R1 first byte");
        step(1, 12'h0FF, 0, 8'h00, 0, 0, 0, "R1 mid byte");
        step(1, 12'h149, 0, 8'h00, 0, 0, 0, "R1 last byte");
        step(1, 12'h14A, 0, 8'h00, 0, 0, 0, "R1 past end");
        step(1, 12'h1FF, 0, 8'h00, 0, 0, 0, "R1 below base");
        // R3 / R4: option write with hold bit, then release
        step(1, 12'h200, 1, 8'hFF, 0, 0, 0, "R3 write option");
        step(1, 12'h200, 0, 8'h00, 0, 0, 0, "R3 option masked");
        step(1, 12'h200, 0, 8'h00, 0, 0, 0, "R4 pulse dropped");
        step(1, 12'h200, 1, 8'h31, 0, 0, 0, "R3 clear hold");
        step(1, 12'h200, 0, 8'h00, 0, 0, 0, "R3 option readback");
        // R5 / R6 / R8: status and ready flag
        step(1, 12'h202, 1, 8'h04, 0, 0, 0, "R5 write power-down");
        step(1, 12'h202, 0, 8'h00, 0, 0, 0, "R5 status readback");
        step(1, 12'h204, 0, 8'h00, 0, 0, 0, "R6 ready set");
        step(1, 12'h202, 1, 8'hFF, 0, 0, 0, "R5 write all ones");
        step(1, 12'h202, 0, 8'h00, 0, 0, 0, "R5 masked load");
        step(1, 12'h202, 1, 8'h00, 0, 0, 0, "R6 toggle back");
        step(1, 12'h204, 1, 8'hFF, 0, 0, 0, "R8 pin write");
        step(1, 12'h204, 0, 8'h00, 0, 0, 0, "R8 pin unchanged");
        // R2 / R11: socket, unknown offsets, below-base writes
        step(1, 12'h206, 1, 8'hFF, 0, 0, 0, "R2 socket write");
        step(1, 12'h206, 0, 8'h00, 0, 0, 0, "R2 socket reads zero");
        step(1, 12'h201, 1, 8'hFF, 0, 0, 0, "R2 odd offset write");
        step(1, 12'h208, 1, 8'hFF, 0, 0, 0, "R2 unknown offset write");
        step(1, 12'h010, 1, 8'hFF, 0, 0, 0, "R11 below-base write");
        step(1, 12'h200, 0, 8'h00, 0, 0, 0, "R11 option intact");
        step(1, 12'h202, 0, 8'h00, 0, 0, 0, "R11 status intact");
        // R10 / R7 / R9: interrupt level, hiding and gating
        step(1, 12'h202, 0, 8'h00, 1, 0, 0, "R10 request raised");
        step(1, 12'h202, 0, 8'h00, 1, 0, 0, "R10 pending visible");
        step(1, 12'h202, 0, 8'h00, 1, 1, 0, "R7 pending hidden");
        step(1, 12'h202, 0, 8'h00, 0, 0, 1, "R9 soft reset gate");
        step(1, 12'h202, 0, 8'h00, 0, 1, 0, "R9 disable gate");
        step(1, 12'h202, 0, 8'h00, 0, 0, 0, "R9 all clear");
        // R10: write and request on the same edge
        step(1, 12'h202, 1, 8'h02, 0, 0, 0, "R10 write bit1 vs low request");
        step(1, 12'h202, 1, 8'h00, 1, 0, 0, "R10 clear write vs high request");
        step(1, 12'h202, 1, 8'h04, 1, 1, 0, "R10 overlap with power-down");
        step(1, 12'h202, 0, 8'h00, 1, 0, 0, "R10 overlap readback");
        step(1, 12'h204, 0, 8'h00, 1, 0, 0, "R6 ready after overlap");
        // R11: mid-run reset
        step(0, 12'h204, 0, 8'h00, 1, 0, 0, "R11 reset asserted");
        step(1, 12'h204, 0, 8'h00, 0, 0, 0, "R11 ready cleared");
        step(1, 12'h200, 0, 8'h00, 0, 0, 0, "R11 option cleared");
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[2:0])
                3'd0: a = 12'h200;
                3'd1, 3'd5: a = 12'h202;
                3'd2: a = 12'h204;
                3'd3: a = 12'h206;
                3'd4: a = {3'b000, lfsr[11:3]};
                3'd6: a = 12'h203;
                default: a = 12'h1F0;
            endcase
            step(1, a, lfsr[4], lfsr[15:8], lfsr[5], lfsr[6] & lfsr[7],
                 lfsr[8] & lfsr[9] & lfsr[10], "R2 mixed traffic");
        end
        done = 1;
        summary();
        $finish;
    end

endmodule